// File: doc/BRIEF.md
# Region Permission Checker

This block decides whether a single bus access may proceed. A set of memory regions is described to it through flat input vectors: each region has a start address, an end address, a valid bit, a 32-bit rights word, an 8-bit process tag and an 8-bit tag ignore mask. An access is given by its master number, address, kind (read, write or instruction fetch), privilege level (user or supervisor) and process tag. One clock after a request, the block returns a grant or deny decision and, for a deny, a class that says why the access failed.

Masters 0 to 3 are privileged-class masters. Each has separate user and supervisor rights and an optional process tag check. Masters 4 to 7 are plain-class masters. They have only read and write enables and can never fetch. Regions cover whole 32-byte blocks. Overlapping regions add their permissions together. A global enable input turns the whole check off, and every access is then granted.

Top module: `rpc_top`

## Requirements
- R1: Master m in 0..3 owns the 6-bit field at rights-word bits [6m+5:6m]. Its user rights sit in field bits [2:0] as read=bit2, write=bit1, fetch=bit0. Access kind code 0 is read, 1 is write, 2 is fetch, and code 3 is never permitted.
- R2: For masters 0..3 in supervisor mode (`req_super`=1), field bits [4:3] set the rights: 0 gives read/write/fetch, 1 gives read/fetch, 2 gives read/write, and 3 gives the same rights as user mode.
- R3: Master m in 4..7 uses rights-word bits [25+2(m-4):24+2(m-4)], with the upper bit as read enable and the lower bit as write enable. The privilege level has no effect for these masters, and a fetch by one of them is never permitted by any region.
- R4: A region matches address A when A[31:5] lies between start[31:5] and end[31:5], inclusive. The low five bits of start and end have no effect.
- R5: A region whose valid bit is clear never matches.
- R6: While `chk_en` is 0, every request is granted with fault class 0.
- R7: When bit 5 of a privileged master's field is set, the region matches only if `(req_pid ^ region_tag) & ~region_mask` is zero. When that bit is clear, the process tag has no effect.
- R8: The fault class is 0 for a grant. For a deny it is 1 when no region matched, 2 when exactly one region matched, and 3 when two or more regions matched.
- R9: When several regions match, the access is granted if any one of them permits it.
- R10: The decision for a request made at one clock edge appears at the next edge with `dec_valid`=1. A cycle with no request gives `dec_valid`=0, `dec_grant`=0 and fault class 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| chk_en | input | 1 | Global check enable; 0 grants everything |
| req_valid | input | 1 | Request present this cycle |
| req_master | input | 3 | Master number 0..7 |
| req_addr | input | 32 | Access byte address |
| req_kind | input | 2 | 0 read, 1 write, 2 fetch |
| req_super | input | 1 | 1 supervisor, 0 user |
| req_pid | input | 8 | Process tag of the access |
| rgn_start | input | NREG*32 | Region start addresses, region r at [32r+31:32r] |
| rgn_end | input | NREG*32 | Region end addresses |
| rgn_valid | input | NREG | Region valid bits |
| rgn_rights | input | NREG*32 | Region rights words |
| rgn_tag | input | NREG*8 | Region process tags |
| rgn_tmask | input | NREG*8 | Region tag ignore masks (1 = ignore bit) |
| dec_valid | output | 1 | Decision present |
| dec_grant | output | 1 | Access granted |
| dec_fault | output | 2 | Fault class per R8 |

## Verification
The assertions assume that the region vectors and `chk_en` stay stable from the request edge until the decision is sampled, and that `req_master` stays within 0..7. The stimulus changes descriptors only between requests and always drives valid master numbers. Random region bounds are kept inside a small address window so that overlaps, misses and boundary blocks all occur often. Directed cases cover every supervisor code, the unaligned start and end bits, masked tag matches and an overlapping pair whose rights combine.

// File: rtl/rpc_pkg.sv
package rpc_pkg;
  localparam int ADDR_W   = 32;
  localparam int BLK_BITS = 5;
  localparam int TAG_W    = 8;
  localparam int MID_W    = 3;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_FETCH = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_kind_e;

  typedef enum logic [1:0] {
    FLT_NONE    = 2'd0,
    FLT_NOHIT   = 2'd1,
    FLT_SINGLE  = 2'd2,
    FLT_OVERLAP = 2'd3
  } fault_e;

  typedef struct packed {
    logic rd;
    logic wr;
    logic ex;
  } rights_t;

  function automatic rights_t sup_map(input logic [1:0] code, input rights_t usr);
    rights_t r;
    case (code)
      2'd0:    r = '{rd: 1'b1, wr: 1'b1, ex: 1'b1};
      2'd1:    r = '{rd: 1'b1, wr: 1'b0, ex: 1'b1};
      2'd2:    r = '{rd: 1'b1, wr: 1'b1, ex: 1'b0};
      default: r = usr;
    endcase
    return r;
  endfunction

  function automatic logic kind_ok(input rights_t r, input acc_kind_e k);
    case (k)
      ACC_READ:  return r.rd;
      ACC_WRITE: return r.wr;
      ACC_FETCH: return r.ex;
      default:   return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/rpc_rights_dec.sv
module rpc_rights_dec
  import rpc_pkg::*;
#(
  parameter int PERM_W      = 32,
  parameter int PRIV_CNT    = 4,
  parameter int PRIV_FLD_W  = 6,
  parameter int PLAIN_BASE  = 24,
  parameter int PLAIN_FLD_W = 2
) (
  input  logic [PERM_W-1:0] perm,
  input  logic [MID_W-1:0]  master,
  input  logic              super_mode,
  output rights_t           rights,
  output logic              tag_chk
);
  localparam int USR_W = 3;

  logic [PRIV_FLD_W-1:0]  pfld;
  logic [PLAIN_FLD_W-1:0] nfld;
  rights_t                usr;
  int unsigned            pidx;
  int unsigned            nidx;

  always_comb begin
    pidx    = 32'(master) * PRIV_FLD_W;
    nidx    = PLAIN_BASE + (32'(master) - PRIV_CNT) * PLAIN_FLD_W;
    pfld    = '0;
    nfld    = '0;
    usr     = '0;
    rights  = '0;
    tag_chk = 1'b0;
    if (32'(master) < PRIV_CNT) begin
      pfld    = perm[pidx +: PRIV_FLD_W];
      usr     = rights_t'(pfld[USR_W-1:0]);
      rights  = super_mode ? sup_map(pfld[USR_W +: 2], usr) : usr;
      tag_chk = pfld[PRIV_FLD_W-1];
    end else begin
      nfld   = perm[nidx +: PLAIN_FLD_W];
      rights = '{rd: nfld[1], wr: nfld[0], ex: 1'b0};
    end
  end
endmodule

// File: rtl/rpc_rgn_match.sv
module rpc_rgn_match
  import rpc_pkg::*;
#(
  parameter int AW     = ADDR_W,
  parameter int PERM_W = 32,
  parameter int TW     = TAG_W
) (
  input  logic [AW-1:0]     r_start,
  input  logic [AW-1:0]     r_end,
  input  logic              r_valid,
  input  logic [PERM_W-1:0] r_perm,
  input  logic [TW-1:0]     r_tag,
  input  logic [TW-1:0]     r_tmask,
  input  logic [AW-1:0]     addr,
  input  logic [MID_W-1:0]  master,
  input  logic              super_mode,
  input  logic [TW-1:0]     pid,
  input  acc_kind_e         kind,
  output logic              hit,
  output logic              allow
);
  localparam logic [AW-1:0] LOW_MASK = AW'((1 << BLK_BITS) - 1);

  rights_t rts;
  logic    tag_chk;
  logic [AW-1:0] lo_eff, hi_eff;
  logic    in_range, tag_ok;

  rpc_rights_dec #(.PERM_W(PERM_W)) u_dec (
    .perm       (r_perm),
    .master     (master),
    .super_mode (super_mode),
    .rights     (rts),
    .tag_chk    (tag_chk)
  );

  always_comb begin
    lo_eff   = r_start & ~LOW_MASK;
    hi_eff   = r_end | LOW_MASK;
    in_range = (addr >= lo_eff) && (addr <= hi_eff);
    tag_ok   = !tag_chk || (((pid ^ r_tag) & ~r_tmask) == '0);
    hit      = r_valid && in_range && tag_ok;
    allow    = hit && kind_ok(rts, kind);
  end
endmodule

// File: rtl/rpc_top.sv
module rpc_top
  import rpc_pkg::*;
#(
  parameter int NREG   = 8,
  parameter int AW     = ADDR_W,
  parameter int PERM_W = 32,
  parameter int TW     = TAG_W
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 chk_en,
  input  logic                 req_valid,
  input  logic [MID_W-1:0]     req_master,
  input  logic [AW-1:0]        req_addr,
  input  logic [1:0]           req_kind,
  input  logic                 req_super,
  input  logic [TW-1:0]        req_pid,
  input  logic [NREG*AW-1:0]   rgn_start,
  input  logic [NREG*AW-1:0]   rgn_end,
  input  logic [NREG-1:0]      rgn_valid,
  input  logic [NREG*PERM_W-1:0] rgn_rights,
  input  logic [NREG*TW-1:0]   rgn_tag,
  input  logic [NREG*TW-1:0]   rgn_tmask,
  output logic                 dec_valid,
  output logic                 dec_grant,
  output logic [1:0]           dec_fault
);
  localparam int CNT_W = $clog2(NREG + 1);

  initial begin
    if (NREG != 8 && NREG != 12 && NREG != 16)
      $error("rpc_top: NREG must be 8, 12 or 16");
  end

  logic [NREG-1:0] hit_vec, allow_vec;
  logic [CNT_W-1:0] hit_cnt;
  logic            grant_c;
  fault_e          fault_c;
  acc_kind_e       kind;

  assign kind = acc_kind_e'(req_kind);

  for (genvar r = 0; r < NREG; r++) begin : g_rgn
    rpc_rgn_match #(.AW(AW), .PERM_W(PERM_W), .TW(TW)) u_match (
      .r_start    (rgn_start[r*AW +: AW]),
      .r_end      (rgn_end[r*AW +: AW]),
      .r_valid    (rgn_valid[r]),
      .r_perm     (rgn_rights[r*PERM_W +: PERM_W]),
      .r_tag      (rgn_tag[r*TW +: TW]),
      .r_tmask    (rgn_tmask[r*TW +: TW]),
      .addr       (req_addr),
      .master     (req_master),
      .super_mode (req_super),
      .pid        (req_pid),
      .kind       (kind),
      .hit        (hit_vec[r]),
      .allow      (allow_vec[r])
    );
  end

  always_comb begin
    hit_cnt = CNT_W'($countones(hit_vec));
    grant_c = !chk_en || (|allow_vec);
    if (grant_c)            fault_c = FLT_NONE;
    else if (hit_cnt == '0) fault_c = FLT_NOHIT;
    else if (hit_cnt == 1)  fault_c = FLT_SINGLE;
    else                    fault_c = FLT_OVERLAP;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dec_valid <= 1'b0;
      dec_grant <= 1'b0;
      dec_fault <= 2'd0;
    end else begin
      dec_valid <= req_valid;
      dec_grant <= req_valid && grant_c;
      dec_fault <= req_valid ? fault_c : FLT_NONE;
    end
  end

  AST_GRANT_CLEAN: assert property (@(posedge clk) disable iff (rst)
    dec_valid && dec_grant |-> dec_fault == 2'd0); // R8
  AST_DENY_CLASSED: assert property (@(posedge clk) disable iff (rst)
    dec_valid && !dec_grant |-> dec_fault != 2'd0); // R8
  AST_NOHIT_CLASS: assert property (@(posedge clk) disable iff (rst)
    req_valid && chk_en && hit_vec == '0 |=> !dec_grant && dec_fault == 2'd1); // R8
  AST_BYPASS: assert property (@(posedge clk) disable iff (rst)
    req_valid && !chk_en |=> dec_grant && dec_fault == 2'd0); // R6
  AST_PLAIN_NO_FETCH: assert property (@(posedge clk) disable iff (rst)
    req_valid && chk_en && req_master >= 3'd4 && req_kind == 2'd2 |=> !dec_grant); // R3
  AST_RESP_TIMING: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> dec_valid); // R10
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !dec_valid |-> !dec_grant && dec_fault == 2'd0); // R10
endmodule

// File: tb/rpc_top_bench.sv
module rpc_top_bench;
  localparam int NREG = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic        chk_en = 1'b0, req_valid = 1'b0, req_super = 1'b0;
  logic [2:0]  req_master = '0;
  logic [31:0] req_addr = '0;
  logic [1:0]  req_kind = '0;
  logic [7:0]  req_pid = '0;
  logic [31:0] st [NREG];
  logic [31:0] en [NREG];
  logic [31:0] pm [NREG];
  logic [7:0]  tg [NREG];
  logic [7:0]  mk [NREG];
  logic [NREG-1:0] vld = '0;
  logic [NREG*32-1:0] f_st, f_en, f_pm;
  logic [NREG*8-1:0]  f_tg, f_mk;
  logic dec_valid, dec_grant;
  logic [1:0] dec_fault;

  for (genvar r = 0; r < NREG; r++) begin : g_pack
    assign f_st[r*32 +: 32] = st[r];
    assign f_en[r*32 +: 32] = en[r];
    assign f_pm[r*32 +: 32] = pm[r];
    assign f_tg[r*8 +: 8]   = tg[r];
    assign f_mk[r*8 +: 8]   = mk[r];
  end

  rpc_top #(.NREG(NREG)) u_rpc_top (
    .clk(clk), .rst(rst), .chk_en(chk_en), .req_valid(req_valid),
    .req_master(req_master), .req_addr(req_addr), .req_kind(req_kind),
    .req_super(req_super), .req_pid(req_pid), .rgn_start(f_st),
    .rgn_end(f_en), .rgn_valid(vld), .rgn_rights(f_pm), .rgn_tag(f_tg),
    .rgn_tmask(f_mk), .dec_valid(dec_valid), .dec_grant(dec_grant),
    .dec_fault(dec_fault)
  );

  int total = 0, bad = 0;

  task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Reference model: returns {valid, grant, fault}
  function automatic logic [3:0] model();
    int hits = 0;
    logic ok = 1'b0;
    for (int r = 0; r < NREG; r++) begin
      logic rd, wr, ex;
      logic [5:0] f6;
      logic [1:0] f2;
      if (!vld[r]) continue;
      if (req_addr[31:5] < st[r][31:5] || req_addr[31:5] > en[r][31:5]) continue;
      if (req_master < 4) begin
        f6 = pm[r][6*req_master +: 6];
        if (f6[5] && (((req_pid ^ tg[r]) & ~mk[r]) != 8'h00)) continue;
        {rd, wr, ex} = f6[2:0];
        if (req_super) begin
          if (f6[4:3] == 2'd0) {rd, wr, ex} = 3'b111;
          else if (f6[4:3] == 2'd1) {rd, wr, ex} = 3'b101;
          else if (f6[4:3] == 2'd2) {rd, wr, ex} = 3'b110;
        end
      end else begin
        f2 = pm[r][24 + 2*(req_master-4) +: 2];
        rd = f2[1]; wr = f2[0]; ex = 1'b0;
      end
      hits++;
      if ((req_kind == 0 && rd) || (req_kind == 1 && wr) || (req_kind == 2 && ex)) ok = 1'b1;
    end
    if (!chk_en || ok) return 4'b1100;
    if (hits == 0) return 4'b1001;
    if (hits == 1) return 4'b1010;
    return 4'b1011;
  endfunction

  task automatic access(input string req, input logic [2:0] m, input logic [31:0] a,
                        input logic [1:0] k, input logic s, input logic [7:0] p,
                        input logic [3:0] exp);
    logic [3:0] mexp;
    @(negedge clk);
    req_master = m; req_addr = a; req_kind = k; req_super = s; req_pid = p;
    req_valid = 1'b1;
    mexp = model();
    @(posedge clk); #1;
    check(req, {dec_valid, dec_grant, dec_fault}, exp);
    if (mexp !== exp) $display("note: directed expectation differs from model for %s", req);
    @(negedge clk); req_valid = 1'b0;
  endtask

  task automatic clear_rgn();
    for (int r = 0; r < NREG; r++) begin
      st[r] = '0; en[r] = '0; pm[r] = '0; tg[r] = '0; mk[r] = '0;
    end
    vld = '0;
  endtask

  initial begin : watchdog
    #1_500_000;
    bad++; total++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    clear_rgn();
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    #1 check("R10 reset", {dec_valid, dec_grant, dec_fault}, 4'b0000);

    // R6: bypass with nothing valid
    access("R6 bypass", 3'd0, 32'h100, 2'd1, 1'b0, 8'h0, 4'b1100);
    chk_en = 1'b1;
    access("R8 no hit", 3'd0, 32'h100, 2'd0, 1'b0, 8'h0, 4'b1001);

    // R1/R2: master 0, user read only, supervisor code 0
    st[0] = 32'h100; en[0] = 32'h1FF; vld[0] = 1'b1; pm[0] = 32'h0000_0004;
    access("R1 user read", 3'd0, 32'h140, 2'd0, 1'b0, 8'h0, 4'b1100);
    access("R1 user write denied", 3'd0, 32'h140, 2'd1, 1'b0, 8'h0, 4'b1010);
    access("R1 kind 3 denied", 3'd0, 32'h140, 2'd3, 1'b1, 8'h0, 4'b1010);
    access("R2 sup code0 write", 3'd0, 32'h140, 2'd1, 1'b1, 8'h0, 4'b1100);
    pm[0] = 32'h0000_000C;  // sup code 1 = RX
    access("R2 sup code1 write denied", 3'd0, 32'h140, 2'd1, 1'b1, 8'h0, 4'b1010);
    access("R2 sup code1 fetch", 3'd0, 32'h140, 2'd2, 1'b1, 8'h0, 4'b1100);
    pm[0] = 32'h0000_0014;  // sup code 2 = RW
    access("R2 sup code2 fetch denied", 3'd0, 32'h140, 2'd2, 1'b1, 8'h0, 4'b1010);
    pm[0] = 32'h0000_001C;  // sup code 3 = user (R)
    access("R2 sup code3 read", 3'd0, 32'h140, 2'd0, 1'b1, 8'h0, 4'b1100);
    access("R2 sup code3 write denied", 3'd0, 32'h140, 2'd1, 1'b1, 8'h0, 4'b1010);

    // R4: granularity
    pm[0] = 32'h0000_0007; st[0] = 32'h105; en[0] = 32'h1E0;
    access("R4 start block", 3'd0, 32'h100, 2'd0, 1'b0, 8'h0, 4'b1100);
    access("R4 end block", 3'd0, 32'h1FF, 2'd0, 1'b0, 8'h0, 4'b1100);
    access("R4 above", 3'd0, 32'h200, 2'd0, 1'b0, 8'h0, 4'b1001);
    access("R4 below", 3'd0, 32'h0FF, 2'd0, 1'b0, 8'h0, 4'b1001);

    // R3: master 5 read only
    pm[0] = 32'h0800_0000 | 32'h0400_0000 * 0;  // bits[27:26] = 2'b10
    access("R3 plain read", 3'd5, 32'h120, 2'd0, 1'b0, 8'h0, 4'b1100);
    access("R3 plain write denied", 3'd5, 32'h120, 2'd1, 1'b1, 8'h0, 4'b1010);
    pm[0] = 32'hFF00_0000;
    access("R3 plain fetch denied", 3'd5, 32'h120, 2'd2, 1'b1, 8'h0, 4'b1010);
    access("R3 plain write", 3'd7, 32'h120, 2'd1, 1'b0, 8'h0, 4'b1100);

    // R5: valid bit
    vld[0] = 1'b0;
    access("R5 invalid region", 3'd7, 32'h120, 2'd1, 1'b0, 8'h0, 4'b1001);

    // R7: tag check on master 1 (field bits 11:6)
    vld[0] = 1'b1; pm[0] = 32'h0000_0FC0; tg[0] = 8'h5A; mk[0] = 8'h0F;
    access("R7 masked tag match", 3'd1, 32'h120, 2'd1, 1'b0, 8'h53, 4'b1100);
    access("R7 tag mismatch", 3'd1, 32'h120, 2'd1, 1'b0, 8'h63, 4'b1001);
    pm[0] = 32'h0000_07C0;
    access("R7 tag check off", 3'd1, 32'h120, 2'd1, 1'b0, 8'h63, 4'b1100);

    // R9: overlap combines rights
    st[0] = 32'h100; en[0] = 32'h1FF; pm[0] = 32'h0000_0004;
    st[1] = 32'h080; en[1] = 32'h17F; pm[1] = 32'h0000_0002; vld[1] = 1'b1;
    access("R9 overlap write", 3'd0, 32'h110, 2'd1, 1'b0, 8'h0, 4'b1100);
    access("R9 overlap read", 3'd0, 32'h110, 2'd0, 1'b0, 8'h0, 4'b1100);
    access("R8 overlap deny", 3'd0, 32'h110, 2'd2, 1'b0, 8'h0, 4'b1011);

    // R10: idle cycle after request
    @(posedge clk); #1;
    check("R10 idle", {dec_valid, dec_grant, dec_fault}, 4'b0000);

    // Random: model-checked, R1..R9
    void'($urandom(32'd4242));
    for (int i = 0; i < 600; i++) begin
      logic [3:0] e;
      if (i % 20 == 0) begin
        @(negedge clk);
        for (int r = 0; r < NREG; r++) begin
          st[r] = $urandom % 1024;
          en[r] = st[r] + ($urandom % 512);
          pm[r] = $urandom;
          tg[r] = 8'($urandom % 16);
          mk[r] = 8'($urandom);
          vld[r] = ($urandom % 4) != 0;
        end
        chk_en = ($urandom % 8) != 0;
      end
      @(negedge clk);
      req_master = 3'($urandom); req_addr = $urandom % 1600;
      req_kind = 2'($urandom); req_super = 1'($urandom);
      req_pid = 8'($urandom % 16); req_valid = 1'b1;
      e = model();
      @(posedge clk); #1;
      check("R9 random vs model", {dec_valid, dec_grant, dec_fault}, e);
      @(negedge clk); req_valid = 1'b0;
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule